// File: doc/BRIEF.md
# Two-Level Cache Coherence State Controller

This block holds the per-quad coherence bits of a cache placed between an upper shared bus and a lower shared bus. Each quad slot has a valid flag and three state bits. Shared says other copies may exist. Master says this cache owns the current value. Below says a cache on the lower bus may hold the quad. The tag lookup and the data array are outside the block. Decoded commands from both buses arrive with a hit flag and a slot index. The block turns them into state updates, into pulls of the two shared lines, and into a request to forward an upper write-single onto the lower bus.

Read-quad (RQ) and write-single (WS) commands are snooped on both buses. Write-quad on the upper bus is never snooped. A Store seen above clears Master only when the owning transaction commits. A victim index announced in the third cycle of a lower RQ clears Below. The clear is cancelled if another cache pulls the lower shared line in the following cycle. When several events reach one slot in the same clock, a fixed order settles them: upper-side effects first, then lower-bus effects.

Top module: `coh_state_ctrl`

## Requirements
- R1: After a synchronous reset, every slot reads valid=0, Shared=0, Master=0, Below=0, and no line pull or forward request is asserted.
- R2: A fill of a slot makes it valid with Shared=1, Master=0 and Below=0 from the next cycle on.
- R3: A lower WS that hits sets Master in the next cycle. An upper WS that hits does not change Master. Master is cleared in the cycle after the next commit pulse.
- R4: The upper shared-line pull is asserted in the same cycle as an upper RQ or WS that hits a valid slot. The lower pull is asserted for a lower RQ or WS that hits a valid slot only when that slot's Shared bit is 1.
- R5: A lower RQ that hits a valid slot sets Below from the next cycle on.
- R6: A victim index given in cycle t clears Below from cycle t+2 if the lower shared-line input is low in cycle t+1. If that input is high in cycle t+1, Below stays set.
- R7: The forward request is asserted in the same cycle as an upper WS that hits a valid slot whose Below bit is 1, and it is low when Below is 0.
- R8: When this cache issues a WS above, that slot's Shared bit takes the upper shared-line input from the next cycle on.
- R9: Commands that miss (hit low, or slot not valid) on either bus, and upper write-quad commands (command code 3), cause no pull, no forward and no state change. Command codes are: 0 none, 1 RQ, 2 WS, 3 WQ.
- R10: Within one cycle on the same slot, lower-bus events act after upper-side ones. A lower WS together with a commit leaves Master=1. A lower RQ together with a pending victim clear leaves Below=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_cmd | input | 2 | Snooped upper-bus command code |
| up_hit | input | 1 | Tag hit for the upper command |
| up_idx | input | IW | Slot index of the upper command |
| lo_cmd | input | 2 | Lower-bus command code |
| lo_hit | input | 1 | Tag hit for the lower command |
| lo_idx | input | IW | Slot index of the lower command |
| fill_en | input | 1 | Fresh quad loaded into a slot |
| fill_idx | input | IW | Slot being filled |
| iss_ws_en | input | 1 | This cache issues a WS above |
| iss_ws_idx | input | IW | Slot of the issued WS |
| up_shared_in | input | 1 | Upper shared-line sample for the issued WS |
| vict_en | input | 1 | Victim index valid (third cycle of a lower RQ) |
| vict_idx | input | IW | Victim slot index |
| lo_shared_in | input | 1 | Lower shared-line sample in the cycle after the victim |
| commit | input | 1 | Commit of the pending upper Store |
| obs_idx | input | IW | Slot whose state is shown on the obs outputs |
| pull_up_o | output | 1 | Pull the upper shared line |
| pull_lo_o | output | 1 | Pull the lower shared line |
| fwd_ws_o | output | 1 | Reissue the snooped upper WS on the lower bus |
| obs_valid | output | 1 | Valid flag of the observed slot |
| obs_shared | output | 1 | Shared bit of the observed slot |
| obs_master | output | 1 | Master bit of the observed slot |
| obs_below | output | 1 | Below bit of the observed slot |

## Verification
The assertions assume that at most one upper Store waits for commit at a time. Each commit pulse must follow the upper WS it belongs to, and no second upper WS may arrive before that commit. They also assume the victim index is presented for a single cycle, with the lower shared-line sample taken in the cycle after it. The directed stimulus follows these rules. It issues every upper WS and then its commit before starting the next scenario. It drives exactly one victim cycle followed by one sample cycle. Same-slot collisions are created only in the ordering scenario, and there on purpose.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RQ   = 2'd1,
    CMD_WS   = 2'd2,
    CMD_WQ   = 2'd3
  } bus_cmd_e;

  typedef struct packed {
    logic valid;
    logic shared;
    logic master;
    logic below;
  } qstate_t;

  typedef struct packed {
    logic fill;
    logic clr_master;
    logic iss_ws;
    logic iss_shared;
    logic clr_below;
    logic set_below;
    logic set_master;
  } qev_t;

  // Commands that the snoop logic reacts to (write-quad is never snooped).
  function automatic logic cmd_snooped(input bus_cmd_e c);
    return (c == CMD_RQ) || (c == CMD_WS);
  endfunction

  // Next state of one slot; upper-side effects first, then lower-bus effects.
  function automatic qstate_t qs_next(input qstate_t s, input qev_t e);
    qstate_t n;
    n = s;
    if (e.fill) begin
      n.valid  = 1'b1;
      n.shared = 1'b1;
      n.master = 1'b0;
      n.below  = 1'b0;
    end
    if (n.valid) begin
      if (e.clr_master) n.master = 1'b0;
      if (e.iss_ws)     n.shared = e.iss_shared;
      if (e.clr_below)  n.below  = 1'b0;
      if (e.set_below)  n.below  = 1'b1;
      if (e.set_master) n.master = 1'b1;
    end
    return n;
  endfunction

endpackage

// File: rtl/coh_qslot.sv
module coh_qslot
  import coh_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  qev_t    ev,
  output qstate_t st
);
  always_ff @(posedge clk) begin
    if (rst) st <= '0;
    else     st <= qs_next(st, ev);
  end
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int NQ = 16,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [1:0]    up_cmd,
  input  logic          up_hit,
  input  logic [IW-1:0] up_idx,
  input  logic [1:0]    lo_cmd,
  input  logic          lo_hit,
  input  logic [IW-1:0] lo_idx,
  input  logic [NQ-1:0] valid_vec,
  input  logic [NQ-1:0] shared_vec,
  input  logic [NQ-1:0] below_vec,
  output logic          pull_up,
  output logic          pull_lo,
  output logic          fwd_ws,
  output logic          up_ws_hit,
  output logic          lo_rq_hit,
  output logic          lo_ws_hit
);
  bus_cmd_e uc, lc;
  logic     up_real_hit, lo_real_hit;

  assign uc = bus_cmd_e'(up_cmd);
  assign lc = bus_cmd_e'(lo_cmd);
  assign up_real_hit = up_hit && valid_vec[up_idx];
  assign lo_real_hit = lo_hit && valid_vec[lo_idx];

  assign pull_up   = up_real_hit && cmd_snooped(uc);
  assign pull_lo   = lo_real_hit && cmd_snooped(lc) && shared_vec[lo_idx];
  assign up_ws_hit = up_real_hit && (uc == CMD_WS);
  assign fwd_ws    = up_ws_hit && below_vec[up_idx];
  assign lo_rq_hit = lo_real_hit && (lc == CMD_RQ);
  assign lo_ws_hit = lo_real_hit && (lc == CMD_WS);
endmodule

// File: rtl/coh_defer.sv
module coh_defer #(
  parameter int NQ = 16,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_ws_hit,
  input  logic [IW-1:0] up_idx,
  input  logic          commit,
  input  logic          vict_en,
  input  logic [IW-1:0] vict_idx,
  input  logic [NQ-1:0] valid_vec,
  input  logic          lo_shared_in,
  output logic          clr_m_en,
  output logic [IW-1:0] clr_m_idx,
  output logic          clr_x_en,
  output logic [IW-1:0] clr_x_idx
);
  logic          mpend_v, xpend_v;
  logic [IW-1:0] mpend_idx, xpend_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mpend_v   <= 1'b0;
      mpend_idx <= '0;
      xpend_v   <= 1'b0;
      xpend_idx <= '0;
    end else begin
      if (up_ws_hit) begin
        mpend_v   <= 1'b1;
        mpend_idx <= up_idx;
      end else if (commit) begin
        mpend_v <= 1'b0;
      end
      xpend_v   <= vict_en && valid_vec[vict_idx];
      xpend_idx <= vict_idx;
    end
  end

  assign clr_m_en  = commit && mpend_v;
  assign clr_m_idx = mpend_idx;
  assign clr_x_en  = xpend_v && !lo_shared_in;
  assign clr_x_idx = xpend_idx;
endmodule

// File: rtl/coh_state_ctrl.sv
module coh_state_ctrl
  import coh_pkg::*;
#(
  parameter int NQ = 16,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    up_cmd,
  input  logic          up_hit,
  input  logic [IW-1:0] up_idx,
  input  logic [1:0]    lo_cmd,
  input  logic          lo_hit,
  input  logic [IW-1:0] lo_idx,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  input  logic          iss_ws_en,
  input  logic [IW-1:0] iss_ws_idx,
  input  logic          up_shared_in,
  input  logic          vict_en,
  input  logic [IW-1:0] vict_idx,
  input  logic          lo_shared_in,
  input  logic          commit,
  input  logic [IW-1:0] obs_idx,
  output logic          pull_up_o,
  output logic          pull_lo_o,
  output logic          fwd_ws_o,
  output logic          obs_valid,
  output logic          obs_shared,
  output logic          obs_master,
  output logic          obs_below
);
  logic [NQ-1:0] valid_vec, shared_vec, master_vec, below_vec;
  logic          up_ws_hit, lo_rq_hit, lo_ws_hit;
  logic          clr_m_en, clr_x_en;
  logic [IW-1:0] clr_m_idx, clr_x_idx;
  qstate_t       st_arr [NQ];

  coh_snoop #(.NQ(NQ)) u_snoop (
    .up_cmd(up_cmd), .up_hit(up_hit), .up_idx(up_idx),
    .lo_cmd(lo_cmd), .lo_hit(lo_hit), .lo_idx(lo_idx),
    .valid_vec(valid_vec), .shared_vec(shared_vec), .below_vec(below_vec),
    .pull_up(pull_up_o), .pull_lo(pull_lo_o), .fwd_ws(fwd_ws_o),
    .up_ws_hit(up_ws_hit), .lo_rq_hit(lo_rq_hit), .lo_ws_hit(lo_ws_hit)
  );

  coh_defer #(.NQ(NQ)) u_defer (
    .clk(clk), .rst(rst), .up_ws_hit(up_ws_hit), .up_idx(up_idx),
    .commit(commit), .vict_en(vict_en), .vict_idx(vict_idx),
    .valid_vec(valid_vec), .lo_shared_in(lo_shared_in),
    .clr_m_en(clr_m_en), .clr_m_idx(clr_m_idx),
    .clr_x_en(clr_x_en), .clr_x_idx(clr_x_idx)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_slot
    qev_t ev;
    always_comb begin
      ev.fill       = fill_en   && (fill_idx   == IW'(q));
      ev.clr_master = clr_m_en  && (clr_m_idx  == IW'(q));
      ev.iss_ws     = iss_ws_en && (iss_ws_idx == IW'(q));
      ev.iss_shared = up_shared_in;
      ev.clr_below  = clr_x_en  && (clr_x_idx  == IW'(q));
      ev.set_below  = lo_rq_hit && (lo_idx     == IW'(q));
      ev.set_master = lo_ws_hit && (lo_idx     == IW'(q));
    end
    coh_qslot u_slot (.clk(clk), .rst(rst), .ev(ev), .st(st_arr[q]));
    assign valid_vec[q]  = st_arr[q].valid;
    assign shared_vec[q] = st_arr[q].shared;
    assign master_vec[q] = st_arr[q].master;
    assign below_vec[q]  = st_arr[q].below;
  end

  assign obs_valid  = valid_vec[obs_idx];
  assign obs_shared = shared_vec[obs_idx];
  assign obs_master = master_vec[obs_idx];
  assign obs_below  = below_vec[obs_idx];
endmodule

// File: rtl/coh_state_chk.sv
module coh_state_chk #(
  parameter int NQ = 16,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    lo_cmd,
  input logic          lo_hit,
  input logic [IW-1:0] lo_idx,
  input logic          fill_en,
  input logic [IW-1:0] fill_idx,
  input logic          iss_ws_en,
  input logic [IW-1:0] iss_ws_idx,
  input logic          commit,
  input logic          clr_x_en,
  input logic          pull_up_o,
  input logic          fwd_ws_o,
  input logic [NQ-1:0] valid_vec,
  input logic [NQ-1:0] shared_vec,
  input logic [NQ-1:0] master_vec,
  input logic [NQ-1:0] below_vec
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (valid_vec == '0 && master_vec == '0 && below_vec == '0));

  // R2
  fill_state_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !(iss_ws_en && iss_ws_idx == fill_idx)) |=>
      (valid_vec[$past(fill_idx)] && shared_vec[$past(fill_idx)]));

  // R3
  master_clear_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(master_vec) & ~master_vec) != '0) && !$past(rst)) |->
      $past(commit || fill_en));

  // R5
  below_set_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_cmd == 2'd1 && lo_hit && valid_vec[lo_idx]) |=> below_vec[$past(lo_idx)]);

  // R6
  below_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(below_vec) & ~below_vec) != '0) && !$past(rst)) |->
      $past(clr_x_en || fill_en));

  // R7
  fwd_needs_snoop_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_ws_o |-> pull_up_o);
endmodule

bind coh_state_ctrl coh_state_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst(rst), .lo_cmd(lo_cmd), .lo_hit(lo_hit), .lo_idx(lo_idx),
  .fill_en(fill_en), .fill_idx(fill_idx), .iss_ws_en(iss_ws_en),
  .iss_ws_idx(iss_ws_idx), .commit(commit), .clr_x_en(clr_x_en),
  .pull_up_o(pull_up_o), .fwd_ws_o(fwd_ws_o), .valid_vec(valid_vec),
  .shared_vec(shared_vec), .master_vec(master_vec), .below_vec(below_vec)
);

// File: tb/sim_coh_state_ctrl.sv
module sim_coh_state_ctrl;
  localparam int CLK_P = 10;
  localparam int NQ = 16;
  localparam int IW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] up_cmd, lo_cmd;
  logic up_hit, lo_hit, fill_en, iss_ws_en, up_shared_in, vict_en, lo_shared_in, commit;
  logic [IW-1:0] up_idx, lo_idx, fill_idx, iss_ws_idx, vict_idx, obs_idx;
  logic pull_up_o, pull_lo_o, fwd_ws_o, obs_valid, obs_shared, obs_master, obs_below;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  coh_state_ctrl #(.NQ(NQ)) u0 (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    up_cmd = 0; up_hit = 0; up_idx = 0; lo_cmd = 0; lo_hit = 0; lo_idx = 0;
    fill_en = 0; fill_idx = 0; iss_ws_en = 0; iss_ws_idx = 0; up_shared_in = 0;
    vict_en = 0; vict_idx = 0; lo_shared_in = 0; commit = 0;
  endtask

  // one clock edge, then back to the falling edge with inputs idle
  task automatic tick();
    @(posedge clk); @(negedge clk); idle(); #1;
  endtask

  task automatic look(string req, int q, int v, int s, int m, int b);
    obs_idx = IW'(q); #1;
    chk(req, "valid", obs_valid, v);
    chk(req, "shared", obs_shared, s);
    chk(req, "master", obs_master, m);
    chk(req, "below", obs_below, b);
  endtask

  task automatic t_reset();
    for (int q = 0; q < NQ; q++) look("R1", q, 0, 0, 0, 0);
    chk("R1", "pulls", {pull_up_o, pull_lo_o, fwd_ws_o}, 0);
  endtask

  task automatic t_fill();
    fill_en = 1; fill_idx = 3; tick();
    look("R2", 3, 1, 1, 0, 0);
  endtask

  task automatic t_lower();
    lo_cmd = 2; lo_hit = 1; lo_idx = 3; #1;
    chk("R4", "pull_lo shared WS", pull_lo_o, 1);
    tick(); look("R3", 3, 1, 1, 1, 0);
    lo_cmd = 1; lo_hit = 1; lo_idx = 3; #1;
    chk("R4", "pull_lo shared RQ", pull_lo_o, 1);
    tick(); look("R5", 3, 1, 1, 1, 1);
  endtask

  task automatic t_upper_ws();
    up_cmd = 2; up_hit = 1; up_idx = 3; #1;
    chk("R4", "pull_up WS", pull_up_o, 1);
    chk("R7", "fwd with below", fwd_ws_o, 1);
    tick(); look("R3", 3, 1, 1, 1, 1);
    tick(); look("R3", 3, 1, 1, 1, 1);
    commit = 1; tick(); look("R3", 3, 1, 1, 0, 1);
    fill_en = 1; fill_idx = 5; tick();
    up_cmd = 1; up_hit = 1; up_idx = 5; #1;
    chk("R4", "pull_up RQ", pull_up_o, 1);
    chk("R7", "no fwd on RQ", fwd_ws_o, 0);
    tick();
    up_cmd = 2; up_hit = 1; up_idx = 5; #1;
    chk("R7", "no fwd without below", fwd_ws_o, 0);
    tick(); commit = 1; tick();
    look("R3", 5, 1, 1, 0, 0);
  endtask

  task automatic t_issue();
    iss_ws_en = 1; iss_ws_idx = 5; up_shared_in = 0; tick();
    look("R8", 5, 1, 0, 0, 0);
    lo_cmd = 1; lo_hit = 1; lo_idx = 5; #1;
    chk("R4", "no pull_lo when not shared", pull_lo_o, 0);
    tick(); look("R5", 5, 1, 0, 0, 1);
    iss_ws_en = 1; iss_ws_idx = 5; up_shared_in = 1; tick();
    look("R8", 5, 1, 1, 0, 1);
  endtask

  task automatic t_victim();
    vict_en = 1; vict_idx = 3; tick();
    lo_shared_in = 1; tick();
    look("R6", 3, 1, 1, 0, 1);
    vict_en = 1; vict_idx = 3; tick();
    look("R6", 3, 1, 1, 0, 1);
    lo_shared_in = 0; tick();
    look("R6", 3, 1, 1, 0, 0);
  endtask

  task automatic t_miss();
    lo_cmd = 2; lo_hit = 1; lo_idx = 5; tick();
    look("R3", 5, 1, 1, 1, 1);
    up_cmd = 1; up_hit = 0; up_idx = 5; #1;
    chk("R9", "pull_up on miss", pull_up_o, 0);
    tick();
    up_cmd = 2; up_hit = 1; up_idx = 7; #1;
    chk("R9", "pull_up invalid slot", pull_up_o, 0);
    chk("R9", "fwd invalid slot", fwd_ws_o, 0);
    tick();
    up_cmd = 3; up_hit = 1; up_idx = 5; #1;
    chk("R9", "pull_up on WQ", pull_up_o, 0);
    chk("R9", "fwd on WQ", fwd_ws_o, 0);
    tick(); commit = 1; tick();
    look("R9", 5, 1, 1, 1, 1);
    up_cmd = 2; up_hit = 0; up_idx = 5; tick(); commit = 1; tick();
    look("R9", 5, 1, 1, 1, 1);
    lo_cmd = 2; lo_hit = 1; lo_idx = 9; #1;
    chk("R9", "pull_lo invalid slot", pull_lo_o, 0);
    tick(); look("R9", 9, 0, 0, 0, 0);
  endtask

  task automatic t_order();
    up_cmd = 2; up_hit = 1; up_idx = 5; #1;
    chk("R7", "fwd with below", fwd_ws_o, 1);
    tick();
    commit = 1; lo_cmd = 2; lo_hit = 1; lo_idx = 5; tick();
    look("R10", 5, 1, 1, 1, 1);
    vict_en = 1; vict_idx = 5; tick();
    lo_shared_in = 0; lo_cmd = 1; lo_hit = 1; lo_idx = 5; tick();
    look("R10", 5, 1, 1, 1, 1);
  endtask

  initial begin
    idle(); obs_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); t_reset();
    rst = 0; #1;
    t_reset();
    t_fill();
    t_lower();
    t_upper_ws();
    t_issue();
    t_victim();
    t_miss();
    t_order();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule